// File: doc/BRIEF.md
# Tagged Conditional Skip Controller

This block sits next to an instruction decoder and decides, one instruction at a time, whether the instruction is carried out or suppressed. A conditional instruction (COND) carries a 4-bit label and compares two register values. If the values are equal, the controller enters a suppression state that is bound to that label.

While suppression is active, every instruction is squashed. This continues until a closing instruction (CLOSE) with the same label arrives. That closing instruction is squashed as well, and the instruction after it runs normally. A CLOSE that does not end an active suppression does nothing.

A program can therefore hold up to sixteen labelled regions. Ending a program with one CLOSE for each label value always leaves the controller back in execute mode.

Top module: `cond_skip_unit`

## Requirements
- R1: After synchronous active-high reset the controller is in execute mode: a valid instruction of any class sees `exec_en` = 1.
- R2: `exec_en` is 0 whenever `instr_valid` is 0. With `instr_valid` at 0 the suppression state and its label do not change, whatever the other inputs are.
- R3: A valid COND (op_class 2'b01) seen in execute mode with `reg_a` == `reg_b` is itself executed (`exec_en` = 1). Every following valid instruction is then suppressed.
- R4: A valid COND seen in execute mode with `reg_a` != `reg_b` is executed and does not start suppression.
- R5: While suppression is active, every valid instruction of class 2'b00 or 2'b11 (ordinary), COND, or CLOSE with a different label sees `exec_en` = 0, and suppression continues.
- R6: While suppression is active, a COND with equal register values and a new label neither ends suppression nor replaces the stored label.
- R7: While suppression is active, a valid CLOSE (op_class 2'b10) whose label equals the stored label sees `exec_en` = 0 and ends suppression. The next valid instruction sees `exec_en` = 1.
- R8: A valid CLOSE seen in execute mode is a no-operation: it sees `exec_en` = 1 and leaves the controller in execute mode.
- R9: Any suppression, whatever its label, is cleared by issuing CLOSE with labels 0 through 15 in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is present this cycle |
| op_class | input | 2 | 00 ordinary, 01 COND, 10 CLOSE, 11 ordinary |
| tag | input | 4 | Label carried by COND or CLOSE |
| reg_a | input | 4 | First compared register value |
| reg_b | input | 4 | Second compared register value |
| exec_en | output | 1 | The current instruction is to be executed |

## Verification
The suppression flag and its label are visible only through `exec_en` on later instructions. A flag that is wrongly set or cleared therefore shows up on the very next valid instruction. A corrupted stored label can stay hidden until the CLOSE that should have matched it, or one that should not have matched it, arrives. For that reason the stimulus keeps the labels within a small range, so that matching and non-matching CLOSE instructions occur often inside long suppressed stretches. Each instruction's enable is compared in the same cycle against a reference model.

// File: rtl/cond_skip_pkg.sv
package cond_skip_pkg;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 4;

  typedef enum logic [1:0] {
    OPC_PLAIN = 2'b00,
    OPC_COND  = 2'b01,
    OPC_CLOSE = 2'b10,
    OPC_SPARE = 2'b11
  } opc_e;

  typedef struct packed {
    logic             active;
    logic [TAG_W-1:0] label;
  } skip_state_t;
endpackage

// File: rtl/skip_eq.sv
module skip_eq #(
  parameter int W = 4
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         same
);
  always_comb same = (lhs == rhs);
endmodule

// File: rtl/skip_next.sv
module skip_next
  import cond_skip_pkg::*;
(
  input  logic        valid,
  input  logic [1:0]  op_raw,
  input  logic [TAG_W-1:0] tag_in,
  input  logic        operands_equal,
  input  logic        label_equal,
  input  skip_state_t cur,
  output skip_state_t nxt,
  output logic        load
);
  opc_e op;
  always_comb begin
    op   = opc_e'(op_raw);
    nxt  = cur;
    load = valid;
    if (valid) begin
      if (cur.active) begin
        if (op == OPC_CLOSE && label_equal) nxt.active = 1'b0;
      end else if (op == OPC_COND && operands_equal) begin
        nxt.active = 1'b1;
        nxt.label  = tag_in;
      end
    end
  end
endmodule

// File: rtl/skip_state_reg.sv
module skip_state_reg
  import cond_skip_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  skip_state_t nxt,
  output skip_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur.active <= 1'b0;
      cur.label  <= '0;
    end else if (load) begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/cond_skip_unit.sv
module cond_skip_unit
  import cond_skip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [1:0]        op_class,
  input  logic [TAG_W-1:0]  tag,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  output logic              exec_en
);
  logic        ops_same;
  logic        lbl_same;
  logic        st_load;
  skip_state_t st_cur;
  skip_state_t st_nxt;

  skip_eq #(.W(DATA_W)) u_ops (
    .lhs (reg_a),
    .rhs (reg_b),
    .same(ops_same)
  );

  skip_eq #(.W(TAG_W)) u_lbl (
    .lhs (tag),
    .rhs (st_cur.label),
    .same(lbl_same)
  );

  skip_next u_next (
    .valid         (instr_valid),
    .op_raw        (op_class),
    .tag_in        (tag),
    .operands_equal(ops_same),
    .label_equal   (lbl_same),
    .cur           (st_cur),
    .nxt           (st_nxt),
    .load          (st_load)
  );

  skip_state_reg u_state (
    .clk (clk),
    .rst (rst),
    .load(st_load),
    .nxt (st_nxt),
    .cur (st_cur)
  );

  always_comb exec_en = instr_valid & ~st_cur.active;
endmodule

// File: rtl/cond_skip_checks.sv
module cond_skip_checks
  import cond_skip_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [1:0]        op_class,
  input logic [TAG_W-1:0]  tag,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b,
  input logic              exec_en,
  input skip_state_t       st_cur
);
  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> !exec_en);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(st_cur));

  p_enter_r3: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !st_cur.active && op_class == 2'b01 && reg_a == reg_b)
    |=> (st_cur.active && st_cur.label == $past(tag)));

  p_stay_r4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !st_cur.active && !(op_class == 2'b01 && reg_a == reg_b))
    |=> !st_cur.active);

  p_squash_r5: assert property (@(posedge clk) disable iff (rst)
    st_cur.active |-> !exec_en);

  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && st_cur.active && !(op_class == 2'b10 && tag == st_cur.label))
    |=> (st_cur.active && $stable(st_cur.label)));

  p_close_r7: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && st_cur.active && op_class == 2'b10 && tag == st_cur.label)
    |=> !st_cur.active);
endmodule

bind cond_skip_unit cond_skip_checks u_checks (
  .clk        (clk),
  .rst        (rst),
  .instr_valid(instr_valid),
  .op_class   (op_class),
  .tag        (tag),
  .reg_a      (reg_a),
  .reg_b      (reg_b),
  .exec_en    (exec_en),
  .st_cur     (st_cur)
);

// File: tb/tb_cond_skip_unit.sv
module tb_cond_skip_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instr_valid = 1'b0;
  logic [1:0] op_class = 2'b00;
  logic [3:0] tag = 4'd0;
  logic [3:0] reg_a = 4'd0;
  logic [3:0] reg_b = 4'd0;
  logic       exec_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit       m_active = 1'b0;
  bit [3:0] m_label = 4'd0;

  cond_skip_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .op_class(op_class),
    .tag(tag), .reg_a(reg_a), .reg_b(reg_b), .exec_en(exec_en)
  );

  always #5 clk = ~clk;

  function automatic bit exp_en(bit v);
    return v && !m_active;
  endfunction

  task automatic check(string req, logic got, logic expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s: exec_en=%0b expected=%0b at %0t", req, got, expv, $time);
    end
  endtask

  task automatic model_step(bit v, bit [1:0] op, bit [3:0] t, bit [3:0] a, bit [3:0] b);
    if (v) begin
      if (m_active) begin
        if (op == 2'b10 && t == m_label) m_active = 1'b0;
      end else if (op == 2'b01 && a == b) begin
        m_active = 1'b1;
        m_label  = t;
      end
    end
  endtask

  task automatic issue(string req, bit v, bit [1:0] op, bit [3:0] t, bit [3:0] a, bit [3:0] b);
    @(negedge clk);
    instr_valid = v; op_class = op; tag = t; reg_a = a; reg_b = b;
    #1;
    check(req, exec_en, exp_en(v));
    model_step(v, op, t, a, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    issue("R1", 1, 2'b00, 4'd0, 4'd0, 4'd0);
    issue("R1", 1, 2'b11, 4'd0, 4'd1, 4'd2);
    issue("R2", 0, 2'b01, 4'd3, 4'd5, 4'd5);
    issue("R2", 1, 2'b00, 4'd0, 4'd0, 4'd0);
    issue("R4", 1, 2'b01, 4'd6, 4'd2, 4'd9);
    issue("R4", 1, 2'b00, 4'd0, 4'd0, 4'd0);
    issue("R8", 1, 2'b10, 4'd6, 4'd0, 4'd0);
    issue("R8", 1, 2'b00, 4'd0, 4'd0, 4'd0);
    issue("R3", 1, 2'b01, 4'd9, 4'd7, 4'd7);
    issue("R3", 1, 2'b00, 4'd0, 4'd0, 4'd0);
    issue("R5", 1, 2'b10, 4'd8, 4'd0, 4'd0);
    issue("R6", 1, 2'b01, 4'd4, 4'd1, 4'd1);
    issue("R6", 1, 2'b10, 4'd4, 4'd0, 4'd0);
    issue("R2", 0, 2'b10, 4'd9, 4'd0, 4'd0);
    issue("R5", 1, 2'b11, 4'd0, 4'd0, 4'd0);
    issue("R7", 1, 2'b10, 4'd9, 4'd0, 4'd0);
    issue("R7", 1, 2'b00, 4'd0, 4'd0, 4'd0);
    issue("R3", 1, 2'b01, 4'd15, 4'd0, 4'd0);
    for (int t = 0; t < 16; t++) issue("R9", 1, 2'b10, 4'(t), 4'd0, 4'd0);
    issue("R9", 1, 2'b00, 4'd0, 4'd0, 4'd0);

    for (int n = 0; n < 4000; n++) begin
      bit v;
      bit [1:0] op;
      bit [3:0] t, a, b;
      string r;
      v  = ($urandom % 8) != 0;
      op = 2'($urandom);
      t  = 4'($urandom % 3);
      a  = 4'($urandom);
      b  = (($urandom % 2) != 0) ? a : 4'($urandom);
      if (!v) r = "R2";
      else if (m_active) r = "R5";
      else r = "R1";
      issue(r, v, op, t, a, b);
    end

    issue("R3", 1, 2'b01, 4'd12, 4'd3, 4'd3);
    for (int t = 0; t < 16; t++) issue("R9", 1, 2'b10, 4'(t), 4'd0, 4'd0);
    issue("R9", 1, 2'b01, 4'd1, 4'd1, 4'd2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule